// File: doc/BRIEF.md
# USB Endpoint Handshake Status Register

This block holds the control and status flags for one IN and one OUT endpoint of a USB device function. It sits between a CPU register bus and the packet buffer logic. Software writes whole bytes to it. Hardware reports packet events on single-cycle strobes. The block merges the two sources so that neither loses an event.

Each flag owned by hardware has one write value that does nothing. Software can therefore rewrite a full byte without first reading it back and masking it. The block also enforces the buffer-mode rules:
- Auto-set only works with a single buffer.
- Auto-flush only works with a double buffer.
- An OUT flush only acts on a packet that is actually held.

Clearing the OUT ready flag in the middle of a packet read is refused. The refusal is reported on a pulse. While the bus-reset status input is high, every endpoint flag and control bit is held at its reset value.

Top module: `usb_ep_csr`

## Requirements
- R1: While `rst_n` is low, or one clock edge after `usb_reset` is sampled high, every flag, the stall bits, the auto bits and `in_slot_o` are 0. Writes and event strobes in a cycle with `usb_reset` high have no effect.
- R2: `rd_data` shows the selected register in the same cycle. `rd_sel`=0 selects IN, 1 selects OUT.
  - IN register: bit0 packet-ready, bit1 underrun, bit4 stall, bit5 auto-set, bit6 flush (write-only, reads 0), bit7 auto-flush.
  - OUT register: bit0 packet-ready, bit1 overrun, bit4 stall, bit5 data-error, bit6 flush (write-only, reads 0).
  - All other bits read 0.
- R3: IN packet-ready is set by a write with bit0=1, and this works whether or not auto-set is on. A write with bit0=0 leaves it unchanged. `in_tx_done` clears it.
- R4: IN underrun is set when `in_token` arrives while IN packet-ready is 0. A write with bit1=1 leaves it unchanged. A write with bit1=0 clears it.
- R5: OUT packet-ready, overrun and data-error are set by `out_rx_done`, `out_ovr_evt` and `out_err_evt` respectively. A write of 1 to their bits (0, 1, 5) leaves them unchanged. A write of 0 clears them.
- R6: A hardware set and a software clear of the same flag in the same cycle leave the flag at 1. No read-advance pulse follows.
- R7: When auto-set is 1 and `double_buf` is 0, `in_load_full` sets IN packet-ready. When `double_buf` is 1, `in_load_full` has no effect.
- R8: When auto-flush is 1 and `double_buf` is 1, `in_tx_done` toggles `in_slot_o` and pulses `in_flush_o` for one cycle. When `double_buf` is 0, neither happens.
- R9: A write to IN bit6=1 pulses `in_flush_o` for one cycle. It also clears IN packet-ready unless the same write sets it.
- R10: A write to OUT bit6=1 while OUT packet-ready is 1 pulses `out_flush_o`, clears the flag and gives no read advance. While OUT packet-ready is 0, the same write does nothing.
- R11: A write that clears OUT packet-ready while `out_rd_busy` is 0 pulses `rd_adv_o` for one cycle.
- R12: A write that clears OUT packet-ready while `out_rd_busy` is 1 leaves the flag at 1. It pulses `clr_misuse_o` instead of `rd_adv_o`.
- R13: Each stall bit (bit4) is plain read/write software state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_reset | input | 1 | Bus-reset status level; holds endpoint state cleared |
| double_buf | input | 1 | 1 = double-buffer FIFO mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 IN, 1 OUT |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Read target: 0 IN, 1 OUT |
| rd_data | output | 8 | Live register value |
| in_tx_done | input | 1 | IN packet transmitted |
| in_token | input | 1 | IN token received |
| in_load_full | input | 1 | IN FIFO loaded with a full max packet |
| out_rx_done | input | 1 | OUT packet received |
| out_ovr_evt | input | 1 | OUT overrun detected |
| out_err_evt | input | 1 | OUT data error detected |
| out_rd_busy | input | 1 | CPU is mid-way through reading an OUT packet |
| in_flush_o | output | 1 | Pulse: discard or retire IN buffer slot |
| in_slot_o | output | 1 | Active IN buffer slot in double-buffer mode |
| out_flush_o | output | 1 | Pulse: discard held OUT packet |
| rd_adv_o | output | 1 | Pulse: advance OUT FIFO read pointer |
| clr_misuse_o | output | 1 | Pulse: mid-read clear refused |

## Verification
A wrong flag shows up on `rd_data` in the cycle right after the edge that produced it, because reads are combinational. Each check therefore compares the full byte of both registers together with the four pulse outputs and the slot bit. Pulses last exactly one cycle, so a missing, doubled or misrouted pulse is seen one edge after the triggering write or event. Ignored-write cases are read back at the port immediately after the write, before any other stimulus.

// File: rtl/usb_ep_csr.sv
module usb_ep_csr #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_reset,
  input  logic             double_buf,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             in_tx_done,
  input  logic             in_token,
  input  logic             in_load_full,
  input  logic             out_rx_done,
  input  logic             out_ovr_evt,
  input  logic             out_err_evt,
  input  logic             out_rd_busy,
  output logic             in_flush_o,
  output logic             in_slot_o,
  output logic             out_flush_o,
  output logic             rd_adv_o,
  output logic             clr_misuse_o
);

  logic in_rdy, in_unr, in_stall, in_aset, in_aflush;
  logic out_rdy, out_ovr, out_stall, out_derr;

  wire wr_in  = wr_en & ~wr_sel & ~usb_reset;
  wire wr_out = wr_en &  wr_sel & ~usb_reset;

  wire aset_ev   = in_aset & ~double_buf & in_load_full;
  wire aflush_ev = in_aflush & double_buf & in_tx_done;
  wire in_set    = (wr_in & wr_data[0]) | aset_ev;
  wire in_fl_req = wr_in & wr_data[6];
  wire in_clr    = in_tx_done | in_fl_req;

  wire out_fl    = wr_out & wr_data[6] & out_rdy;
  wire sw_clr    = wr_out & ~wr_data[0] & out_rdy & ~wr_data[6];
  wire misuse    = sw_clr & out_rd_busy;
  wire good_clr  = sw_clr & ~out_rd_busy & ~out_rx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {in_rdy, in_unr, in_stall, in_aset, in_aflush, in_slot_o} <= '0;
      {out_rdy, out_ovr, out_stall, out_derr} <= '0;
      {in_flush_o, out_flush_o, rd_adv_o, clr_misuse_o} <= '0;
    end else if (usb_reset) begin
      {in_rdy, in_unr, in_stall, in_aset, in_aflush, in_slot_o} <= '0;
      {out_rdy, out_ovr, out_stall, out_derr} <= '0;
      {in_flush_o, out_flush_o, rd_adv_o, clr_misuse_o} <= '0;
    end else begin
      if (in_set)      in_rdy <= 1'b1;
      else if (in_clr) in_rdy <= 1'b0;

      if (in_token & ~in_rdy)        in_unr <= 1'b1;
      else if (wr_in & ~wr_data[1])  in_unr <= 1'b0;

      if (wr_in) begin
        in_stall  <= wr_data[4];
        in_aset   <= wr_data[5];
        in_aflush <= wr_data[7];
      end
      if (aflush_ev) in_slot_o <= ~in_slot_o;

      if (out_rx_done)             out_rdy <= 1'b1;
      else if (good_clr | out_fl)  out_rdy <= 1'b0;

      if (out_ovr_evt)               out_ovr <= 1'b1;
      else if (wr_out & ~wr_data[1]) out_ovr <= 1'b0;

      if (out_err_evt)               out_derr <= 1'b1;
      else if (wr_out & ~wr_data[5]) out_derr <= 1'b0;

      if (wr_out) out_stall <= wr_data[4];

      in_flush_o   <= in_fl_req | aflush_ev;
      out_flush_o  <= out_fl;
      rd_adv_o     <= good_clr;
      clr_misuse_o <= misuse;
    end
  end

  wire [REG_W-1:0] in_view  = REG_W'({in_aflush, 1'b0, in_aset, in_stall, 2'b00, in_unr, in_rdy});
  wire [REG_W-1:0] out_view = REG_W'({2'b00, out_derr, out_stall, 2'b00, out_ovr, out_rdy});
  assign rd_data = rd_sel ? out_view : in_view;

  p_usbrst_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    usb_reset |=> (!in_rdy && !in_unr && !out_rdy && !out_ovr && !out_derr && !in_slot_o));

  p_outrdy_rise_hw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_rdy) |-> $past(out_rx_done));

  p_hw_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rx_done && !usb_reset) |=> out_rdy);

  p_inrdy_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rdy) |-> ($past(wr_en && !wr_sel && wr_data[0]) || $past(in_load_full && !double_buf)));

  p_slot_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(in_slot_o) && !$past(usb_reset)) |-> $past(double_buf && in_tx_done));

  p_misuse_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_misuse_o |-> out_rdy);

  p_out_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_adv_o, clr_misuse_o, out_flush_o}));

endmodule

// File: tb/sim_usb_ep_csr.sv
`timescale 1ns/1ps
module sim_usb_ep_csr;
  logic clk = 0, rst_n = 0, usb_reset = 0, double_buf = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic in_tx_done = 0, in_token = 0, in_load_full = 0;
  logic out_rx_done = 0, out_ovr_evt = 0, out_err_evt = 0, out_rd_busy = 0;
  logic in_flush_o, in_slot_o, out_flush_o, rd_adv_o, clr_misuse_o;

  always #2 clk = ~clk;

  usb_ep_csr u0 (.*);

  int applied = 0, miscompares = 0;
  bit done = 0;
  logic [12:0] q_exp[$];
  string q_tag[$];

  // Event bits: 0 tx_done, 1 token, 2 load_full, 3 rx_done, 4 ovr, 5 err, 6 rd_busy, 7 usb_reset
  task automatic step(input logic we, input logic sel, input logic [7:0] d, input logic [7:0] ev);
    wr_en = we; wr_sel = sel; wr_data = d;
    {usb_reset, out_rd_busy, out_err_evt, out_ovr_evt, out_rx_done,
     in_load_full, in_token, in_tx_done} = ev;
    @(posedge clk); #1;
    wr_en = 0; wr_data = 0;
    {usb_reset, out_rd_busy, out_err_evt, out_ovr_evt, out_rx_done,
     in_load_full, in_token, in_tx_done} = '0;
  endtask

  // pulses: {in_flush, out_flush, rd_adv, misuse}
  task automatic expect_rd(input logic sel, input logic [7:0] b, input logic [3:0] p,
                           input logic slot, input string tag);
    rd_sel = sel;
    q_exp.push_back({p, slot, b});
    q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  initial forever begin
    @(negedge clk);
    if (q_exp.size() > 0) begin
      logic [12:0] e, a;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = {in_flush_o, out_flush_o, rd_adv_o, clr_misuse_o, in_slot_o, rd_data};
      applied++;
      if (a !== e) begin
        miscompares++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    expect_rd(0, 8'h00, 4'b0000, 0, "R1 reset IN");
    rst_n = 1;
    @(negedge clk); #1;
    expect_rd(0, 8'h00, 4'b0000, 0, "R1 IN after reset");
    expect_rd(1, 8'h00, 4'b0000, 0, "R1 OUT after reset");

    step(1, 0, 8'h11, 8'h00); expect_rd(0, 8'h11, 4'b0000, 0, "R3 R13 set rdy+stall");
    step(1, 0, 8'h00, 8'h00); expect_rd(0, 8'h01, 4'b0000, 0, "R3 write0 ignored");
    step(0, 0, 8'h00, 8'h01); expect_rd(0, 8'h00, 4'b0000, 0, "R3 tx_done clears");
    step(0, 0, 8'h00, 8'h02); expect_rd(0, 8'h02, 4'b0000, 0, "R4 underrun set");
    step(1, 0, 8'h02, 8'h00); expect_rd(0, 8'h02, 4'b0000, 0, "R4 write1 ignored");
    step(1, 0, 8'h00, 8'h00); expect_rd(0, 8'h00, 4'b0000, 0, "R4 write0 clears");

    step(1, 0, 8'h20, 8'h00); expect_rd(0, 8'h20, 4'b0000, 0, "R2 auto-set readback");
    step(0, 0, 8'h00, 8'h04); expect_rd(0, 8'h21, 4'b0000, 0, "R7 auto-set single");
    step(0, 0, 8'h00, 8'h01); expect_rd(0, 8'h20, 4'b0000, 0, "R3 sent");
    step(1, 0, 8'h21, 8'h00); expect_rd(0, 8'h21, 4'b0000, 0, "R3 sw set with auto-set");
    step(0, 0, 8'h00, 8'h01); expect_rd(0, 8'h20, 4'b0000, 0, "R3 sent again");
    double_buf = 1;
    step(0, 0, 8'h00, 8'h04); expect_rd(0, 8'h20, 4'b0000, 0, "R7 auto-set ignored double");

    step(1, 0, 8'hA0, 8'h00); expect_rd(0, 8'hA0, 4'b0000, 0, "R2 auto-flush readback");
    step(0, 0, 8'h00, 8'h01); expect_rd(0, 8'hA0, 4'b1000, 1, "R8 auto-flush swap");
    expect_rd(0, 8'hA0, 4'b0000, 1, "R8 pulse one cycle");
    double_buf = 0;
    step(0, 0, 8'h00, 8'h01); expect_rd(0, 8'hA0, 4'b0000, 1, "R8 ignored single");

    step(1, 0, 8'hA1, 8'h00); expect_rd(0, 8'hA1, 4'b0000, 1, "R3 set rdy");
    step(1, 0, 8'hC0, 8'h00); expect_rd(0, 8'h80, 4'b1000, 1, "R9 R2 IN flush");

    step(0, 0, 8'h00, 8'h08); expect_rd(1, 8'h01, 4'b0000, 1, "R5 rx sets rdy");
    step(1, 1, 8'h03, 8'h00); expect_rd(1, 8'h01, 4'b0000, 1, "R5 write1 ignored");
    step(0, 0, 8'h00, 8'h30); expect_rd(1, 8'h23, 4'b0000, 1, "R5 ovr+err set");
    step(1, 1, 8'h01, 8'h00); expect_rd(1, 8'h01, 4'b0000, 1, "R5 write0 clears ovr,err");

    step(1, 1, 8'h00, 8'h40); expect_rd(1, 8'h01, 4'b0001, 1, "R12 mid-read clear refused");
    step(1, 1, 8'h00, 8'h00); expect_rd(1, 8'h00, 4'b0010, 1, "R11 clear advances");

    step(0, 0, 8'h00, 8'h08); expect_rd(1, 8'h01, 4'b0000, 1, "R5 rx again");
    step(1, 1, 8'h00, 8'h18); expect_rd(1, 8'h03, 4'b0000, 1, "R6 hw set wins");
    step(1, 1, 8'h00, 8'h00); expect_rd(1, 8'h00, 4'b0010, 1, "R11 clear after R6");

    step(1, 1, 8'h40, 8'h00); expect_rd(1, 8'h00, 4'b0000, 1, "R10 flush ignored empty");
    step(0, 0, 8'h00, 8'h08); expect_rd(1, 8'h01, 4'b0000, 1, "R5 rx for flush");
    step(1, 1, 8'h41, 8'h00); expect_rd(1, 8'h00, 4'b0100, 1, "R10 OUT flush");
    step(1, 1, 8'h10, 8'h00); expect_rd(1, 8'h10, 4'b0000, 1, "R13 OUT stall");

    step(1, 0, 8'h01, 8'h00); expect_rd(0, 8'h01, 4'b0000, 1, "R3 rdy before bus reset");
    step(1, 0, 8'h11, 8'h88); expect_rd(0, 8'h00, 4'b0000, 0, "R1 bus reset IN");
    expect_rd(1, 8'h00, 4'b0000, 0, "R1 bus reset OUT");

    while (q_exp.size() > 0) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule